// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of a small 8-bit microcontroller. It drives eight pins from two state registers and reports their levels through a third. The direction register picks, pin by pin, whether the pad is driven. The level register does two jobs. On a driven pin it sets the output level. On an undriven pin it switches the weak pull-up on or off.

The CPU reaches the port through a simple synchronous register bus. Each cycle the bus can do a full byte write, a single-bit set or a single-bit clear on one selected register. Reads are combinational on the selected address. The pin-sense register cannot be loaded. Any one written to it flips the matching level bit, whatever the pin's direction, which gives software a one-cycle pin toggle. Pad inputs pass through a two-flop synchronizer before software can see them.

Top module: `gpio_port`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, the direction and level registers hold zero, so `pad_oe`, `pad_out` and `pad_pu` are all zero.
- R2: Address 0 selects the direction register, 1 the level register and 2 the pin-sense register. Address 3 reads as zero, and writes, bit sets and bit clears to it change nothing.
- R3: A byte write to address 0 loads the direction register on the next clock edge. A bit value of 1 makes that pin an output (`pad_oe` bit high) and 0 makes it an input.
- R4: A byte write to address 1 loads the level register on the next clock edge, and `pad_out` equals that register.
- R5: `pad_pu` equals the level register ANDed with the inverted direction register, for every combination of the two.
- R6: Reading address 2 returns `pad_in` delayed by two clock edges. A change on `pad_in` is not visible after one edge and is visible after the second.
- R7: A byte write to address 2 inverts every level bit whose write-data bit is 1 and leaves the level bits whose write-data bit is 0 unchanged. The result does not depend on the direction register, and the direction register is not touched.
- R8: A bit set or bit clear at address 0 or 1 forces only bit `bus_bidx` of that register to 1 or 0. The other seven bits keep their values.
- R9: A bit set at address 2 inverts only level bit `bus_bidx`. A bit clear at address 2 has no effect on any register.
- R10: When several strobes are high in one cycle, the byte write wins over the bit set, and the bit set wins over the bit clear.
- R11: Reads of addresses 0 and 1 return the current direction and level registers in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 level, 2 pin-sense |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bidx | input | 3 | Bit index for set and clear |
| bus_rdata | output | 8 | Read data of the selected register |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_in | input | 8 | Raw pin levels |

## Verification
The bench sweeps every pairing of direction and level values. A pull-up term that ignored the direction bit, or used the wrong polarity, would show up there as a pull-up on a driven pin or a missing pull-up on an input pin. Every toggle mask is written to the pin-sense address under a non-trivial direction value. A design that gated the toggle with the direction bit, or loaded the mask as data, would leave wrong level bits. Bit set and clear are run on each bit index of each address, starting from all-zero, all-one and mixed values. A merge that spilled into neighbouring bits would fail here, as would a clear at the pin-sense address that altered the level register. The synchronizer is probed one edge and two edges after each input change, which catches a chain that is one stage too short or too long.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    ADR_DIR  = 2'd0,
    ADR_LVL  = 2'd1,
    ADR_SNS  = 2'd2,
    ADR_NONE = 2'd3
  } gpio_addr_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_BYTE = 2'd1,
    OP_BSET = 2'd2,
    OP_BCLR = 2'd3
  } gpio_op_e;

  // Strobe priority: byte write, then bit set, then bit clear.
  function automatic gpio_op_e pick_op(input logic wr, input logic bset, input logic bclr);
    if (wr)        return OP_BYTE;
    else if (bset) return OP_BSET;
    else if (bclr) return OP_BCLR;
    else           return OP_IDLE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end

    // Each stage holds what the stage before it held one edge earlier.
    assert_sync_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> chain[s] == $past(chain[s-1]));
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gpio_addr_e       addr,
  input  logic             wr,
  input  logic [PINS-1:0]  wdata,
  input  logic             bset,
  input  logic             bclr,
  input  logic [IDX_W-1:0] bidx,
  output logic [PINS-1:0]  dir_q,
  output logic [PINS-1:0]  lvl_q
);

  // One-hot mask for the addressed bit.
  function automatic logic [PINS-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    logic [PINS-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // New value of a plain storage register for one bus operation.
  function automatic logic [PINS-1:0] store_next(input gpio_op_e op,
                                                  input logic [PINS-1:0] cur,
                                                  input logic [PINS-1:0] data,
                                                  input logic [PINS-1:0] m);
    case (op)
      OP_BYTE: return data;
      OP_BSET: return cur | m;
      OP_BCLR: return cur & ~m;
      default: return cur;
    endcase
  endfunction

  // Toggle mask produced by an access to the pin-sense address:
  // ones written there flip level bits; zeros and clears do nothing.
  function automatic logic [PINS-1:0] flip_mask(input gpio_op_e op,
                                                 input logic [PINS-1:0] data,
                                                 input logic [PINS-1:0] m);
    case (op)
      OP_BYTE: return data;
      OP_BSET: return m;
      default: return '0;
    endcase
  endfunction

  gpio_op_e        op;
  logic [PINS-1:0] sel_mask;
  logic            dir_hit;
  logic            lvl_hit;
  logic            sns_hit;
  logic [PINS-1:0] flip_bits;
  logic [PINS-1:0] dir_d;
  logic [PINS-1:0] lvl_d;
  logic            armed_q;

  assign op        = pick_op(wr, bset, bclr);
  assign sel_mask  = bit_mask(bidx);
  assign dir_hit   = (addr == ADR_DIR) && (op != OP_IDLE);
  assign lvl_hit   = (addr == ADR_LVL) && (op != OP_IDLE);
  assign sns_hit   = (addr == ADR_SNS) && (op != OP_IDLE);
  assign flip_bits = sns_hit ? flip_mask(op, wdata, sel_mask) : '0;

  always_comb begin
    dir_d = dir_q;
    lvl_d = lvl_q ^ flip_bits;
    if (dir_hit) dir_d = store_next(op, dir_q, wdata, sel_mask);
    if (lvl_hit) lvl_d = store_next(op, lvl_q, wdata, sel_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      lvl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      lvl_q   <= lvl_d;
      armed_q <= 1'b1;
    end
  end

  assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && addr == ADR_DIR |=> dir_q == $past(wdata));

  assert_lvl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && addr == ADR_LVL |=> lvl_q == $past(wdata));

  assert_toggle_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && addr == ADR_SNS |=> lvl_q == ($past(lvl_q) ^ $past(wdata)) && $stable(dir_q));

  assert_bitop_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !wr && (bset || bclr) && addr == ADR_LVL
    |=> ((lvl_q ^ $past(lvl_q)) & ~$past(sel_mask)) == '0 && $stable(dir_q));

  assert_sense_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !wr && !bset && bclr && addr == ADR_SNS |=> $stable(lvl_q) && $stable(dir_q));

  assert_hole_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && addr == ADR_NONE |=> $stable(lvl_q) && $stable(dir_q));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && bclr && addr == ADR_DIR |=> dir_q == $past(wdata));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  gpio_addr_e      addr,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] lvl_q,
  input  logic [PINS-1:0] sense,
  output logic [PINS-1:0] rdata
);

  always_comb begin
    case (addr)
      ADR_DIR: rdata = dir_q;
      ADR_LVL: rdata = lvl_q;
      ADR_SNS: rdata = sense;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [PINS-1:0]  bus_wdata,
  input  logic             bus_bset,
  input  logic             bus_bclr,
  input  logic [IDX_W-1:0] bus_bidx,
  output logic [PINS-1:0]  bus_rdata,
  output logic [PINS-1:0]  pad_oe,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_pu,
  input  logic [PINS-1:0]  pad_in
);

  gpio_addr_e      addr;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] sense;

  assign addr = gpio_addr_e'(bus_addr);

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sense)
  );

  gpio_regs #(.PINS(PINS), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .bset  (bus_bset),
    .bclr  (bus_bclr),
    .bidx  (bus_bidx),
    .dir_q (dir_q),
    .lvl_q (lvl_q)
  );

  gpio_rdmux #(.PINS(PINS)) u_rdmux (
    .addr  (addr),
    .dir_q (dir_q),
    .lvl_q (lvl_q),
    .sense (sense),
    .rdata (bus_rdata)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign pad_oe[p]  = dir_q[p];
    assign pad_out[p] = lvl_q[p];
    assign pad_pu[p]  = lvl_q[p] & ~dir_q[p];
  end

  // The level and direction registers both reset to zero.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> pad_oe == '0 && pad_out == '0);

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic       bus_bset;
  logic       bus_bclr;
  logic [2:0] bus_bidx;
  logic [7:0] bus_rdata;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;
  logic [7:0] pad_pu;
  logic [7:0] pad_in;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  logic [7:0] m_dir;
  logic [7:0] m_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port i_gpio_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_bset  (bus_bset),
    .bus_bclr  (bus_bclr),
    .bus_bidx  (bus_bidx),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_in    (pad_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Pin outputs against the bench model; pull-up restated bit by bit.
  task automatic check_pads(input string req);
    logic [7:0] pu;
    for (int b = 0; b < 8; b++) pu[b] = (m_dir[b] == 1'b0) ? m_lvl[b] : 1'b0;
    check({req, " R3 oe"}, pad_oe, m_dir);
    check({req, " R4 out"}, pad_out, m_lvl);
    check({req, " R5 pu"}, pad_pu, pu);
  endtask

  task automatic read_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  // Bench reference for one bus cycle: byte write beats set beats clear.
  task automatic model(input logic [1:0] a, input logic wr, input logic [7:0] wd,
                       input logic bs, input logic bc, input logic [2:0] ix);
    for (int b = 0; b < 8; b++) begin
      logic hit;
      hit = (b == int'(ix));
      if (wr) begin
        if (a == 2'd0) m_dir[b] = wd[b];
        if (a == 2'd1) m_lvl[b] = wd[b];
        if (a == 2'd2 && wd[b]) m_lvl[b] = ~m_lvl[b];
      end else if (bs && hit) begin
        if (a == 2'd0) m_dir[b] = 1'b1;
        if (a == 2'd1) m_lvl[b] = 1'b1;
        if (a == 2'd2) m_lvl[b] = ~m_lvl[b];
      end else if (bc && hit) begin
        if (a == 2'd0) m_dir[b] = 1'b0;
        if (a == 2'd1) m_lvl[b] = 1'b0;
      end
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic bus_op(input logic [1:0] a, input logic wr, input logic [7:0] wd,
                        input logic bs, input logic bc, input logic [2:0] ix);
    bus_addr  = a;
    bus_wr    = wr;
    bus_wdata = wd;
    bus_bset  = bs;
    bus_bclr  = bc;
    bus_bidx  = ix;
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_bset = 1'b0;
    bus_bclr = 1'b0;
    model(a, wr, wd, bs, bc, ix);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    bus_bset = 1'b0; bus_bclr = 1'b0; bus_bidx = 3'd0;
    pad_in = 8'h00;
    m_dir = 8'h00; m_lvl = 8'h00;

    // R1: outputs quiet during reset, even with a write strobe present
    repeat (3) @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_wr = 1'b0;
    check_pads("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pads("R1 after reset");
    read_check("R1 dir read", 2'd0, 8'h00);
    read_check("R1 lvl read", 2'd1, 8'h00);

    // R3 R4 R5 R11: every direction/level pairing
    for (int d = 0; d < 256; d++) begin
      bus_op(2'd0, 1'b1, 8'(d), 1'b0, 1'b0, 3'd0);
      read_check("R11 dir readback", 2'd0, 8'(d));
      for (int o = 0; o < 256; o++) begin
        bus_op(2'd1, 1'b1, 8'(o), 1'b0, 1'b0, 3'd0);
        check_pads("R5 sweep");
      end
      read_check("R11 lvl readback", 2'd1, 8'd255);
    end

    // R7: every toggle mask, direction held at a mixed value
    bus_op(2'd0, 1'b1, 8'h3C, 1'b0, 1'b0, 3'd0);
    bus_op(2'd1, 1'b1, 8'h96, 1'b0, 1'b0, 3'd0);
    for (int w = 0; w < 256; w++) begin
      bus_op(2'd2, 1'b1, 8'(w), 1'b0, 1'b0, 3'd0);
      check_pads("R7 toggle");
    end
    bus_op(2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 3'd0);
    check_pads("R7 zero mask");

    // R8 R9: bit set/clear on each address, index and start value
    for (int a = 0; a < 3; a++) begin
      for (int ix = 0; ix < 8; ix++) begin
        for (int s = 0; s < 3; s++) begin
          logic [7:0] start;
          start = (s == 0) ? 8'h00 : (s == 1) ? 8'hFF : 8'hA5;
          bus_op(2'd0, 1'b1, start, 1'b0, 1'b0, 3'd0);
          bus_op(2'd1, 1'b1, ~start, 1'b0, 1'b0, 3'd0);
          bus_op(2'(a), 1'b0, 8'h00, 1'b1, 1'b0, 3'(ix));
          check_pads(a == 2 ? "R9 set" : "R8 set");
          bus_op(2'(a), 1'b0, 8'h00, 1'b0, 1'b1, 3'(ix));
          check_pads(a == 2 ? "R9 clear" : "R8 clear");
        end
      end
    end

    // R2: hole address ignores all operations and reads zero
    bus_op(2'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 3'd0);
    bus_op(2'd1, 1'b1, 8'hC3, 1'b0, 1'b0, 3'd0);
    bus_op(2'd3, 1'b1, 8'hFF, 1'b0, 1'b0, 3'd0);
    check_pads("R2 hole write");
    bus_op(2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 3'd2);
    check_pads("R2 hole set");
    bus_op(2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 3'd6);
    check_pads("R2 hole clear");
    read_check("R2 hole read", 2'd3, 8'h00);

    // R10: strobe priority
    bus_op(2'd1, 1'b1, 8'h0F, 1'b1, 1'b1, 3'd7);
    check_pads("R10 write over set");
    check("R10 write over set", pad_out, 8'h0F);
    bus_op(2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 3'd0);
    check("R10 set over clear", pad_out, 8'h0F);
    bus_op(2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd0);
    check("R10 set over clear dir", pad_oe, 8'h5B);

    // R6: two-edge input synchronizer
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      bus_addr = 2'd2;
      #1;
      prev = bus_rdata;
      pad_in = 8'(v * 37 + 11);
      @(negedge clk);
      read_check("R6 one edge", 2'd2, prev);
      @(negedge clk);
      read_check("R6 two edges", 2'd2, 8'(v * 37 + 11));
    end

    summary();
  end

endmodule